// File: doc/BRIEF.md
# Boot-Time Overlay and Clock-Rate Controller

This block sits between an 8-bit CPU and its boot ROM and RAM. It produces the CPU phase-2 clock from a reference clock `clk`. At full rate the phase-2 period is two `clk` cycles. At half rate it is four `clk` cycles. The block also decodes the address bus into active-low chip enables and drives read and write strobes that are gated by phase 2.

After reset the CPU runs at half rate, and the boot ROM answers reads in the top address region. Writes to that region go to the RAM that lies beneath it, so the reset firmware can copy the ROM image into RAM. The firmware then performs one bus access inside a small reserved trigger window. That access sets a sticky mode flag, and the flag does three things at once:

- The clock is raised to full rate.
- The ROM is unmapped, and the RAM answers reads of the top region.
- If the static protect input is high, the RAM copy in the top region becomes read-only.

Top module: `boot_map_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, `phi2` is low. While `rst` is high, both strobes are high. Directly after reset a read of the top region selects the ROM.
- R2: Before the trigger access, `phi2` alternates two `clk` cycles high and two `clk` cycles low.
- R3: Before the trigger access, a read (`rnw`=1) at address 0xC000–0xFFFF drives `rom_ce_n` low and `ram_ce_n` high. The two enables are never low together.
- R4: Before the trigger access, a write (`rnw`=0) to 0xC000–0xFFFF drives `ram_ce_n` low and keeps `rom_ce_n` high.
- R5: An address below 0xBFF0 selects RAM for both reads and writes in either mode, and never selects the ROM.
- R6: An address in the trigger window 0xBFF0–0xBFFF selects neither memory. An access there sets the mode only if it is present at a `clk` edge while `phi2` is high. A window address seen only while `phi2` is low has no effect. Only `rst` clears the mode.
- R7: Once the mode is set, `rom_ce_n` stays high, and reads of 0xC000–0xFFFF select RAM.
- R8: Once the mode is set, a write to 0xC000–0xFFFF drives `ram_ce_n` high when `wp_en`=1 and low when `wp_en`=0.
- R9: Once the mode is set, `phi2` toggles on every `clk` edge. The rate change takes effect only at the end of a complete low phase, and it coincides with a rising `phi2`.
- R10: `rd_n` is low exactly when `phi2` is high and `rnw`=1. `wr_n` is low exactly when `phi2` is high and `rnw`=0. The chip enables do not depend on `phi2`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, twice the full CPU clock rate |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | CPU address bus |
| rnw | input | 1 | CPU read/write line, 1 = read |
| wp_en | input | 1 | Static enable for write protection of the RAM copy in the top region |
| phi2 | output | 1 | CPU phase-2 clock |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| rd_n | output | 1 | Read strobe gated by phase 2, active low |
| wr_n | output | 1 | Write strobe gated by phase 2, active low |

## Verification
The assertions assume two things about the inputs. First, `addr` and `rnw` hold steady between `clk` edges. Second, `wp_en` does not change in the middle of an access, so each decode result can be attributed to one address/direction pair. The stimulus changes inputs only on falling `clk` edges and samples outputs before the next rising edge. The negative test for R6 places a trigger-window address on the bus during a single low `phi2` cycle and then removes it. It then confirms through the ROM enable that the mode did not change.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;

    typedef enum logic [1:0] {
        RGN_RAM  = 2'd0,
        RGN_TRIG = 2'd1,
        RGN_ROM  = 2'd2
    } region_e;

    typedef struct packed {
        logic rom_sel;
        logic ram_sel;
    } sel_t;

    // True when addr lies in the aligned 2**lg block that starts at base.
    function automatic logic window_hit(input logic [31:0] a,
                                        input logic [31:0] base,
                                        input int          lg);
        return (a >> lg) == (base >> lg);
    endfunction

endpackage

// File: rtl/boot_decode.sv
module boot_decode
    import bootmap_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          ROM_LG    = 14,
    parameter logic [31:0] TRIG_BASE = 32'h0000_BFF0,
    parameter int          TRIG_LG   = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rnw,
    input  logic              mode_set,
    input  logic              wp_en,
    output region_e           region,
    output sel_t              sel
);
    localparam logic [31:0] TOP_MASK = (32'd1 << ADDR_W) - 32'd1;
    localparam logic [31:0] ROM_BASE = TOP_MASK & ~((32'd1 << ROM_LG) - 32'd1);

    logic [31:0] a32;
    assign a32 = 32'(addr);

    always_comb begin
        if (window_hit(a32, ROM_BASE, ROM_LG))
            region = RGN_ROM;
        else if (window_hit(a32, TRIG_BASE, TRIG_LG))
            region = RGN_TRIG;
        else
            region = RGN_RAM;
    end

    always_comb begin
        sel = '0;
        unique case (region)
            RGN_RAM:  sel.ram_sel = 1'b1;
            RGN_TRIG: sel = '0;
            RGN_ROM: begin
                if (!mode_set) begin
                    sel.rom_sel = rnw;
                    sel.ram_sel = ~rnw;
                end else begin
                    sel.ram_sel = rnw | ~wp_en;
                end
            end
            default:  sel = '0;
        endcase
    end

endmodule

// File: rtl/boot_mode_latch.sv
module boot_mode_latch (
    input  logic clk,
    input  logic rst,
    input  logic phi2,
    input  logic trig_hit,
    output logic mode_set
);
    always_ff @(posedge clk) begin
        if (rst)
            mode_set <= 1'b0;
        else if (phi2 && trig_hit)
            mode_set <= 1'b1;
    end

    // R6: once set, the mode only leaves through reset
    p_mode_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        mode_set |=> mode_set);

    // R6: a window address seen while phi2 is low does not set the mode
    p_low_phase_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (!mode_set && !phi2) |=> !mode_set);

endmodule

// File: rtl/boot_clkgen.sv
module boot_clkgen (
    input  logic clk,
    input  logic rst,
    input  logic mode_set,
    output logic phi2,
    output logic fast
);
    logic half_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_cnt <= 1'b0;
            phi2     <= 1'b0;
            fast     <= 1'b0;
        end else if (fast) begin
            half_cnt <= 1'b0;
            phi2     <= ~phi2;
        end else begin
            half_cnt <= ~half_cnt;
            if (half_cnt)
                phi2 <= ~phi2;
            // change rate only when a full low phase has just completed
            if (half_cnt && !phi2 && mode_set)
                fast <= 1'b1;
        end
    end

    p_slow_high_two_r2: assert property (@(posedge clk) disable iff (rst)
        (!fast && $rose(phi2)) |=> phi2);

    p_slow_low_two_r2: assert property (@(posedge clk) disable iff (rst)
        (!fast && $fell(phi2)) |=> !phi2);

    p_fast_toggle_r9: assert property (@(posedge clk) disable iff (rst)
        (fast && $past(fast)) |-> (phi2 != $past(phi2)));

    p_switch_on_rise_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(fast) |-> $rose(phi2));

    p_fast_needs_mode_r9: assert property (@(posedge clk) disable iff (rst)
        fast |-> mode_set);

endmodule

// File: rtl/boot_map_ctrl.sv
module boot_map_ctrl
    import bootmap_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          ROM_LG    = 14,
    parameter logic [31:0] TRIG_BASE = 32'h0000_BFF0,
    parameter int          TRIG_LG   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rnw,
    input  logic              wp_en,
    output logic              phi2,
    output logic              rom_ce_n,
    output logic              ram_ce_n,
    output logic              rd_n,
    output logic              wr_n
);
    logic    mode_set;
    logic    fast;
    region_e region;
    sel_t    sel;

    boot_decode #(
        .ADDR_W   (ADDR_W),
        .ROM_LG   (ROM_LG),
        .TRIG_BASE(TRIG_BASE),
        .TRIG_LG  (TRIG_LG)
    ) u_decode (
        .addr    (addr),
        .rnw     (rnw),
        .mode_set(mode_set),
        .wp_en   (wp_en),
        .region  (region),
        .sel     (sel)
    );

    boot_mode_latch u_mode (
        .clk     (clk),
        .rst     (rst),
        .phi2    (phi2),
        .trig_hit(region == RGN_TRIG),
        .mode_set(mode_set)
    );

    boot_clkgen u_clk (
        .clk     (clk),
        .rst     (rst),
        .mode_set(mode_set),
        .phi2    (phi2),
        .fast    (fast)
    );

    // chip enables: address, direction and mode only
    assign rom_ce_n = ~sel.rom_sel;
    assign ram_ce_n = ~sel.ram_sel;

    // strobes qualified by phase 2 high
    assign rd_n = ~(phi2 & rnw);
    assign wr_n = ~(phi2 & ~rnw);

    p_ce_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        !(!rom_ce_n && !ram_ce_n));

    p_boot_write_ram_r4: assert property (@(posedge clk) disable iff (rst)
        (!mode_set && region == RGN_ROM && !rnw) |-> (!ram_ce_n && rom_ce_n));

    p_no_rom_after_switch_r7: assert property (@(posedge clk) disable iff (rst)
        mode_set |-> rom_ce_n);

    p_write_protect_r8: assert property (@(posedge clk) disable iff (rst)
        (mode_set && wp_en && !rnw && region == RGN_ROM) |-> ram_ce_n);

    p_strobe_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !phi2 |-> (rd_n && wr_n));

    p_strobe_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

endmodule

// File: tb/tb_boot_map_ctrl.sv
module tb_boot_map_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] addr;
    logic        rnw;
    logic        wp_en;
    logic        phi2, rom_ce_n, ram_ce_n, rd_n, wr_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        string req;
        logic  rom;
        logic  ram;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    boot_map_ctrl dut (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .rnw     (rnw),
        .wp_en   (wp_en),
        .phi2    (phi2),
        .rom_ce_n(rom_ce_n),
        .ram_ce_n(ram_ce_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // driver: apply a bus access and queue the expected enables
    task automatic access(string req, logic [15:0] a, logic r, logic rom, logic ram);
        exp_t e;
        @(negedge clk);
        addr = a;
        rnw  = r;
        e.req = req;
        e.rom = rom;
        e.ram = ram;
        sb_q.push_back(e);
    endtask

    // monitor: compare queued expectations after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                check(it.req, "rom_ce_n", 32'(rom_ce_n), 32'(it.rom));
                check(it.req, "ram_ce_n", 32'(ram_ce_n), 32'(it.ram));
            end
        end
    end

    // measure one high and one low run of phi2 in clk cycles
    task automatic measure(string req, int exp_hi, int exp_lo);
        logic prev, cur;
        int   hi, lo;
        @(negedge clk); #1; prev = phi2;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); #1; cur = phi2;
            if (!prev && cur) break;
            prev = cur;
        end
        hi = 1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); #1;
            if (!phi2) break;
            hi++;
        end
        lo = 1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); #1;
            if (phi2) break;
            lo++;
        end
        check(req, "phi2 high cycles", 32'(hi), 32'(exp_hi));
        check(req, "phi2 low cycles", 32'(lo), 32'(exp_lo));
    endtask

    task automatic strobes(string req, logic r);
        @(negedge clk);
        rnw = r;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1;
            check(req, "rd_n", 32'(rd_n), 32'(!(phi2 && r)));
            check(req, "wr_n", 32'(wr_n), 32'(!(phi2 && !r)));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic prev;
        rst   = 1'b1;
        addr  = 16'hC000;
        rnw   = 1'b1;
        wp_en = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R1", "phi2 in reset", 32'(phi2), 32'd0);
        check("R1", "rd_n in reset", 32'(rd_n), 32'd1);
        check("R1", "wr_n in reset", 32'(wr_n), 32'd1);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "phi2 after reset", 32'(phi2), 32'd0);
        access("R1", 16'hC000, 1'b1, 1'b0, 1'b1);

        // R2: half rate before the trigger
        measure("R2", 2, 2);
        measure("R2", 2, 2);

        // R3: boot reads of top region hit ROM; enables hold across phi2 (R10)
        access("R3", 16'hC000, 1'b1, 1'b0, 1'b1);
        access("R3", 16'hFFFC, 1'b1, 1'b0, 1'b1);
        for (int k = 0; k < 4; k++) access("R10", 16'hE123, 1'b1, 1'b0, 1'b1);

        // R4: boot writes to top region fill RAM
        access("R4", 16'hC000, 1'b0, 1'b1, 1'b0);
        access("R4", 16'hFFFF, 1'b0, 1'b1, 1'b0);

        // R5: low memory is RAM
        access("R5", 16'h0200, 1'b1, 1'b1, 1'b0);
        access("R5", 16'h0200, 1'b0, 1'b1, 1'b0);
        access("R5", 16'hBFEF, 1'b1, 1'b1, 1'b0);

        // R10: strobes in slow mode
        strobes("R10", 1'b1);
        strobes("R10", 1'b0);

        // R6: a window address present only during a low phase is ignored
        @(negedge clk); #1; prev = phi2;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); #1;
            if (prev && !phi2) break;
            prev = phi2;
        end
        addr = 16'hBFF4;
        rnw  = 1'b1;
        @(negedge clk);
        addr = 16'h0200;
        access("R6", 16'hC000, 1'b1, 1'b0, 1'b1);
        measure("R6", 2, 2);

        // R6: window selects nothing; qualified access sets the mode
        for (int k = 0; k < 6; k++) access("R6", 16'hBFF5, 1'b1, 1'b1, 1'b1);
        access("R6", 16'h0200, 1'b1, 1'b1, 1'b0);
        repeat (8) @(negedge clk);

        // R7: ROM unmapped, RAM answers top region reads
        access("R7", 16'hC000, 1'b1, 1'b1, 1'b0);
        access("R7", 16'hFFFC, 1'b1, 1'b1, 1'b0);

        // R8: write protection of the copy
        wp_en = 1'b1;
        access("R8", 16'hC000, 1'b0, 1'b1, 1'b1);
        access("R8", 16'hD000, 1'b1, 1'b1, 1'b0);
        access("R5", 16'h0300, 1'b0, 1'b1, 1'b0);
        wp_en = 1'b0;
        access("R8", 16'hC000, 1'b0, 1'b1, 1'b0);

        // R9: full rate
        measure("R9", 1, 1);
        measure("R9", 1, 1);

        // R10: strobes in fast mode
        strobes("R10", 1'b1);
        strobes("R10", 1'b0);

        // R6: reset clears the mode and restores half rate
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        access("R6", 16'hC000, 1'b1, 1'b0, 1'b1);
        measure("R2", 2, 2);

        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule